// File: doc/BRIEF.md
# Floating-Point Operate Instruction Decoder

This block takes one 32-bit floating-point operate instruction word per cycle and classifies it. It recognises the two operate groups (general arithmetic and conversions, and compares), looks up the 9-bit operation code, and reports the size class of each of the three operand positions. It extracts the three register numbers and checks each one against the alignment rule for its size. It also applies the rule that a compare writes the condition code and so must carry a zero destination field.

The result is one of three outcomes: the instruction is accepted, it is unimplemented, or it names an illegal register. A register violation carries a 3-bit trap-type code of 6 for the status register. When it is 0, no violation was found. A downstream emulation or execution stage uses the size classes to steer unpacking and packing. It uses the trap code to raise an invalid-register fault. The result is registered, one cycle after the input strobe.

Top module: `fpdec_top`

## Requirements
- R1: An instruction is in group one when `insn & 0xC1F80000 == 0x81A00000` and in group two when the masked value is `0x81A80000`. Any other word is reported as unimplemented.
- R2: The outputs carry the operation code from bits 13:5, rs1 from bits 18:14, rs2 from bits 4:0 and rd from bits 29:25, whatever the outcome.
- R3: For an accepted operation, each of rs1, rs2 and rd has a class code: 0 none, 1 single, 2 double, 3 quad, 4 raw 32-bit word, 5 condition code. Examples: add 0x041/0x042/0x043 give all three at single/double/quad. Square root 0x029/0x02A/0x02B has no rs1. Multiply single-to-double 0x069 and double-to-quad 0x06E widen the result.
- R4: Move, negate and absolute single (0x001, 0x005, 0x009) report rs2 and rd as raw (4). Integer-to-float conversions (0x0C4, 0x0C8, 0x0CC) report rs2 raw. Float-to-integer conversions (0x0D1, 0x0D2, 0x0D3) report rd raw. Raw operands have no alignment rule.
- R5: A quad-class register number with either of its two low bits set is a register violation.
- R6: A double-class register number with its low bit set is a register violation.
- R7: Compares (0x051/0x052/0x053, and signalling 0x055/0x056/0x057) exist only in group two, with rd of class 5. A non-zero rd field is then a register violation.
- R8: A register violation gives trap code 6. Every other outcome gives trap code 0.
- R9: For an unimplemented instruction, all classes, the violation flag and the trap code are 0.
- R10: The operands are checked in the order rs1, rs2, rd. The first violating one is reported as 1, 2 or 3 respectively; 0 means none.
- R11: Results appear with the output strobe one clock after the input strobe. With no input strobe, and after reset, the strobe and all result outputs are 0.
- R12: While the output strobe is high, exactly one of accepted, unimplemented and register-violation is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_vld | input | 1 | Instruction word strobe |
| in_insn | input | 32 | Instruction word |
| out_vld | output | 1 | Result strobe |
| out_ok | output | 1 | Operation accepted |
| out_unimpl | output | 1 | Unimplemented operation |
| out_badreg | output | 1 | Register violation |
| out_trap | output | 3 | Trap-type code |
| out_badfield | output | 2 | First violating operand |
| out_opc | output | 9 | Operation code |
| out_rs1 | output | 5 | rs1 register number |
| out_rs2 | output | 5 | rs2 register number |
| out_rd | output | 5 | rd register number |
| out_cls_rs1 | output | 3 | rs1 class |
| out_cls_rs2 | output | 3 | rs2 class |
| out_cls_rd | output | 3 | rd class |

## Verification
The properties assume `in_vld` and `in_insn` are fully defined at every clock edge after reset. They also assume reset holds the strobe low. The stimulus drives both only from a task, a fixed delay after each rising edge. It keeps them at known values from time zero. Every word is built from explicit group, code and register fields, so no unknown bits reach the decoder.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

    localparam int WORD_W = 32;
    localparam int OPC_W  = 9;
    localparam int REG_W  = 5;
    localparam int CLS_W  = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE = 3'd0,
        CLS_SGL  = 3'd1,
        CLS_DBL  = 3'd2,
        CLS_QUAD = 3'd3,
        CLS_RAW  = 3'd4,
        CLS_FCC  = 3'd5
    } opnd_cls_e;

    localparam logic [2:0] TRAP_BADREG = 3'd6;

    typedef struct packed {
        logic             vld;
        logic             ok;
        logic             unimpl;
        logic             badreg;
        logic [2:0]       trap;
        logic [1:0]       badfield;
        logic [OPC_W-1:0] opc;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
        logic [REG_W-1:0] rd;
        opnd_cls_e        c1;
        opnd_cls_e        c2;
        opnd_cls_e        cd;
    } dec_t;

endpackage

// File: rtl/fpdec_optable.sv
module fpdec_optable
    import fpdec_pkg::*;
(
    input  logic             grp_two,
    input  logic [OPC_W-1:0] opc,
    output logic             known,
    output opnd_cls_e        c1,
    output opnd_cls_e        c2,
    output opnd_cls_e        cd
);
    always_comb begin
        known = 1'b1;
        c1    = CLS_NONE;
        c2    = CLS_NONE;
        cd    = CLS_NONE;
        if (grp_two) begin
            case (opc)
                9'h051, 9'h055: begin c1 = CLS_SGL;  c2 = CLS_SGL;  cd = CLS_FCC; end
                9'h052, 9'h056: begin c1 = CLS_DBL;  c2 = CLS_DBL;  cd = CLS_FCC; end
                9'h053, 9'h057: begin c1 = CLS_QUAD; c2 = CLS_QUAD; cd = CLS_FCC; end
                default: known = 1'b0;
            endcase
        end else begin
            case (opc)
                9'h001, 9'h005, 9'h009: begin c2 = CLS_RAW; cd = CLS_RAW; end
                9'h029: begin c2 = CLS_SGL;  cd = CLS_SGL;  end
                9'h02A: begin c2 = CLS_DBL;  cd = CLS_DBL;  end
                9'h02B: begin c2 = CLS_QUAD; cd = CLS_QUAD; end
                9'h041, 9'h045, 9'h049, 9'h04D: begin c1 = CLS_SGL;  c2 = CLS_SGL;  cd = CLS_SGL;  end
                9'h042, 9'h046, 9'h04A, 9'h04E: begin c1 = CLS_DBL;  c2 = CLS_DBL;  cd = CLS_DBL;  end
                9'h043, 9'h047, 9'h04B, 9'h04F: begin c1 = CLS_QUAD; c2 = CLS_QUAD; cd = CLS_QUAD; end
                9'h069: begin c1 = CLS_SGL; c2 = CLS_SGL; cd = CLS_DBL;  end
                9'h06E: begin c1 = CLS_DBL; c2 = CLS_DBL; cd = CLS_QUAD; end
                9'h0C4: begin c2 = CLS_RAW;  cd = CLS_SGL;  end
                9'h0C8: begin c2 = CLS_RAW;  cd = CLS_DBL;  end
                9'h0CC: begin c2 = CLS_RAW;  cd = CLS_QUAD; end
                9'h0C6: begin c2 = CLS_DBL;  cd = CLS_SGL;  end
                9'h0C7: begin c2 = CLS_QUAD; cd = CLS_SGL;  end
                9'h0C9: begin c2 = CLS_SGL;  cd = CLS_DBL;  end
                9'h0CB: begin c2 = CLS_QUAD; cd = CLS_DBL;  end
                9'h0CD: begin c2 = CLS_SGL;  cd = CLS_QUAD; end
                9'h0CE: begin c2 = CLS_DBL;  cd = CLS_QUAD; end
                9'h0D1: begin c2 = CLS_SGL;  cd = CLS_RAW;  end
                9'h0D2: begin c2 = CLS_DBL;  cd = CLS_RAW;  end
                9'h0D3: begin c2 = CLS_QUAD; cd = CLS_RAW;  end
                default: known = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fpdec_regchk.sv
module fpdec_regchk
    import fpdec_pkg::*;
#(
    parameter int NUM_W = REG_W
) (
    input  opnd_cls_e        cls,
    input  logic [NUM_W-1:0] num,
    output logic             bad
);
    always_comb begin
        case (cls)
            CLS_QUAD: bad = |num[1:0];
            CLS_DBL:  bad = num[0];
            CLS_FCC:  bad = |num;
            default:  bad = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpdec_top.sv
module fpdec_top
    import fpdec_pkg::*;
#(
    parameter logic [WORD_W-1:0] GRP_MASK = 32'hC1F8_0000,
    parameter logic [WORD_W-1:0] GRP_ONE  = 32'h81A0_0000,
    parameter logic [WORD_W-1:0] GRP_TWO  = 32'h81A8_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] in_insn,
    output logic              out_vld,
    output logic              out_ok,
    output logic              out_unimpl,
    output logic              out_badreg,
    output logic [2:0]        out_trap,
    output logic [1:0]        out_badfield,
    output logic [OPC_W-1:0]  out_opc,
    output logic [REG_W-1:0]  out_rs1,
    output logic [REG_W-1:0]  out_rs2,
    output logic [REG_W-1:0]  out_rd,
    output logic [CLS_W-1:0]  out_cls_rs1,
    output logic [CLS_W-1:0]  out_cls_rs2,
    output logic [CLS_W-1:0]  out_cls_rd
);
    localparam int OPC_LSB = 5;
    localparam int RS2_LSB = 0;
    localparam int RS1_LSB = OPC_LSB + OPC_W;
    localparam int RD_LSB  = 25;
    localparam int N_OPND  = 3;

    logic                        in_g1, in_g2, tbl_known;
    opnd_cls_e                   t_c1, t_c2, t_cd;
    opnd_cls_e                   cls_arr [N_OPND];
    logic [N_OPND-1:0][REG_W-1:0] num_arr;
    logic [N_OPND-1:0]           bad_arr;
    dec_t                        res_d, res_q;

    assign in_g1 = (in_insn & GRP_MASK) == GRP_ONE;
    assign in_g2 = (in_insn & GRP_MASK) == GRP_TWO;

    fpdec_optable u_tbl (
        .grp_two (in_g2),
        .opc     (in_insn[OPC_LSB +: OPC_W]),
        .known   (tbl_known),
        .c1      (t_c1),
        .c2      (t_c2),
        .cd      (t_cd)
    );

    assign cls_arr[0] = t_c1;
    assign cls_arr[1] = t_c2;
    assign cls_arr[2] = t_cd;
    assign num_arr[0] = in_insn[RS1_LSB +: REG_W];
    assign num_arr[1] = in_insn[RS2_LSB +: REG_W];
    assign num_arr[2] = in_insn[RD_LSB  +: REG_W];

    for (genvar g = 0; g < N_OPND; g++) begin : g_chk
        fpdec_regchk #(.NUM_W(REG_W)) u_chk (
            .cls (cls_arr[g]),
            .num (num_arr[g]),
            .bad (bad_arr[g])
        );
    end

    always_comb begin
        res_d = '0;
        if (in_vld) begin
            res_d.vld = 1'b1;
            res_d.opc = in_insn[OPC_LSB +: OPC_W];
            res_d.rs1 = num_arr[0];
            res_d.rs2 = num_arr[1];
            res_d.rd  = num_arr[2];
            if ((in_g1 || in_g2) && tbl_known) begin
                res_d.c1 = t_c1;
                res_d.c2 = t_c2;
                res_d.cd = t_cd;
                if (bad_arr[0])      res_d.badfield = 2'd1;
                else if (bad_arr[1]) res_d.badfield = 2'd2;
                else if (bad_arr[2]) res_d.badfield = 2'd3;
                res_d.badreg = |bad_arr;
                res_d.ok     = ~|bad_arr;
                res_d.trap   = (|bad_arr) ? TRAP_BADREG : 3'd0;
            end else begin
                res_d.unimpl = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_vld      = res_q.vld;
    assign out_ok       = res_q.ok;
    assign out_unimpl   = res_q.unimpl;
    assign out_badreg   = res_q.badreg;
    assign out_trap     = res_q.trap;
    assign out_badfield = res_q.badfield;
    assign out_opc      = res_q.opc;
    assign out_rs1      = res_q.rs1;
    assign out_rs2      = res_q.rs2;
    assign out_rd       = res_q.rd;
    assign out_cls_rs1  = res_q.c1;
    assign out_cls_rs2  = res_q.c2;
    assign out_cls_rd   = res_q.cd;
endmodule

// File: rtl/fpdec_chk.sv
module fpdec_chk
    import fpdec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic [WORD_W-1:0] in_insn,
    input logic              out_vld,
    input logic              out_ok,
    input logic              out_unimpl,
    input logic              out_badreg,
    input logic [2:0]        out_trap,
    input logic [1:0]        out_badfield,
    input logic [OPC_W-1:0]  out_opc,
    input logic [REG_W-1:0]  out_rs1,
    input logic [REG_W-1:0]  out_rs2,
    input logic [REG_W-1:0]  out_rd,
    input logic [CLS_W-1:0]  out_cls_rs1,
    input logic [CLS_W-1:0]  out_cls_rs2,
    input logic [CLS_W-1:0]  out_cls_rd
);
    assert_strobe_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    assert_strobe_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    assert_opcode_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_opc == $past(in_insn[13:5]));
    assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $countones({out_ok, out_unimpl, out_badreg}) == 1);
    assert_unimpl_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_unimpl |-> (!out_badreg && out_trap == 3'd0 && out_cls_rs1 == 3'd0
                        && out_cls_rs2 == 3'd0 && out_cls_rd == 3'd0));
    assert_trap_on_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_badreg |-> out_trap == 3'd6);
    assert_trap_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_badreg |-> out_trap == 3'd0);
    assert_field_named_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_badreg |-> out_badfield != 2'd0);
    assert_fcc_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ok && out_cls_rd == CLS_FCC) |-> out_rd == '0);
    assert_quad_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ok && out_cls_rs2 == CLS_QUAD) |-> out_rs2[1:0] == 2'b00);
    assert_dbl_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ok && out_cls_rs1 == CLS_DBL) |-> !out_rs1[0]);
endmodule

bind fpdec_top fpdec_chk u_fpdec_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_vld       (in_vld),
    .in_insn      (in_insn),
    .out_vld      (out_vld),
    .out_ok       (out_ok),
    .out_unimpl   (out_unimpl),
    .out_badreg   (out_badreg),
    .out_trap     (out_trap),
    .out_badfield (out_badfield),
    .out_opc      (out_opc),
    .out_rs1      (out_rs1),
    .out_rs2      (out_rs2),
    .out_rd       (out_rd),
    .out_cls_rs1  (out_cls_rs1),
    .out_cls_rs2  (out_cls_rs2),
    .out_cls_rd   (out_cls_rd)
);

// File: tb/test_fpdec_top.sv
module test_fpdec_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] in_insn = '0;
    logic        out_vld, out_ok, out_unimpl, out_badreg;
    logic [2:0]  out_trap;
    logic [1:0]  out_badfield;
    logic [8:0]  out_opc;
    logic [4:0]  out_rs1, out_rs2, out_rd;
    logic [2:0]  out_cls_rs1, out_cls_rs2, out_cls_rd;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    typedef struct {
        logic       ok, unimpl, badreg;
        logic [2:0] trap;
        logic [1:0] bf;
        logic [8:0] opc;
        logic [4:0] r1, r2, rd;
        logic [2:0] c1, c2, cd;
        string      tag;
    } exp_t;

    exp_t sb[$];

    fpdec_top i_fpdec_top (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_insn(in_insn),
        .out_vld(out_vld), .out_ok(out_ok), .out_unimpl(out_unimpl),
        .out_badreg(out_badreg), .out_trap(out_trap), .out_badfield(out_badfield),
        .out_opc(out_opc), .out_rs1(out_rs1), .out_rs2(out_rs2), .out_rd(out_rd),
        .out_cls_rs1(out_cls_rs1), .out_cls_rs2(out_cls_rs2), .out_cls_rd(out_cls_rd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Reference table: {known, rs1 class, rs2 class, rd class}
    // classes: 0 none, 1 single, 2 double, 3 quad, 4 raw, 5 condition code
    function automatic logic [9:0] ref_tbl(bit g2, logic [8:0] op);
        if (g2) begin
            case (op)
                9'h051, 9'h055: return {1'b1, 3'd1, 3'd1, 3'd5};
                9'h052, 9'h056: return {1'b1, 3'd2, 3'd2, 3'd5};
                9'h053, 9'h057: return {1'b1, 3'd3, 3'd3, 3'd5};
                default: return '0;
            endcase
        end
        case (op)
            9'h001, 9'h005, 9'h009: return {1'b1, 3'd0, 3'd4, 3'd4};
            9'h029: return {1'b1, 3'd0, 3'd1, 3'd1};
            9'h02A: return {1'b1, 3'd0, 3'd2, 3'd2};
            9'h02B: return {1'b1, 3'd0, 3'd3, 3'd3};
            9'h041, 9'h045, 9'h049, 9'h04D: return {1'b1, 3'd1, 3'd1, 3'd1};
            9'h042, 9'h046, 9'h04A, 9'h04E: return {1'b1, 3'd2, 3'd2, 3'd2};
            9'h043, 9'h047, 9'h04B, 9'h04F: return {1'b1, 3'd3, 3'd3, 3'd3};
            9'h069: return {1'b1, 3'd1, 3'd1, 3'd2};
            9'h06E: return {1'b1, 3'd2, 3'd2, 3'd3};
            9'h0C4: return {1'b1, 3'd0, 3'd4, 3'd1};
            9'h0C8: return {1'b1, 3'd0, 3'd4, 3'd2};
            9'h0CC: return {1'b1, 3'd0, 3'd4, 3'd3};
            9'h0C6: return {1'b1, 3'd0, 3'd2, 3'd1};
            9'h0C7: return {1'b1, 3'd0, 3'd3, 3'd1};
            9'h0C9: return {1'b1, 3'd0, 3'd1, 3'd2};
            9'h0CB: return {1'b1, 3'd0, 3'd3, 3'd2};
            9'h0CD: return {1'b1, 3'd0, 3'd1, 3'd3};
            9'h0CE: return {1'b1, 3'd0, 3'd2, 3'd3};
            9'h0D1: return {1'b1, 3'd0, 3'd1, 3'd4};
            9'h0D2: return {1'b1, 3'd0, 3'd2, 3'd4};
            9'h0D3: return {1'b1, 3'd0, 3'd3, 3'd4};
            default: return '0;
        endcase
    endfunction

    function automatic bit ref_bad(logic [2:0] c, logic [4:0] r);
        if (c == 3'd3) return r[1:0] != 2'b00;   // R5
        if (c == 3'd2) return r[0];              // R6
        if (c == 3'd5) return r != 5'd0;         // R7
        return 1'b0;
    endfunction

    function automatic string bad_tag(logic [2:0] c);
        if (c == 3'd3) return "R5";
        if (c == 3'd2) return "R6";
        return "R7";
    endfunction

    // Driver: builds the word, pushes the expected item, applies it for one cycle.
    task automatic send(logic [1:0] top, logic [5:0] grp, logic [8:0] op,
                        logic [4:0] r1, logic [4:0] r2, logic [4:0] rd);
        exp_t e;
        logic [9:0] t;
        bit fpop, g2;
        logic [31:0] w;
        w = {top, rd, grp, r1, op, r2};
        fpop = (top == 2'b10) && (grp == 6'b110100 || grp == 6'b110101);
        g2 = (grp == 6'b110101);
        t = ref_tbl(g2, op);
        e.opc = op; e.r1 = r1; e.r2 = r2; e.rd = rd;
        e.ok = 0; e.unimpl = 0; e.badreg = 0; e.trap = 0; e.bf = 0;
        e.c1 = 0; e.c2 = 0; e.cd = 0;
        if (!fpop || !t[9]) begin
            e.unimpl = 1;
            e.tag = fpop ? "R9" : "R1";
        end else begin
            e.c1 = t[8:6]; e.c2 = t[5:3]; e.cd = t[2:0];
            if (ref_bad(e.c1, r1))      begin e.bf = 2'd1; e.tag = bad_tag(e.c1); end
            else if (ref_bad(e.c2, r2)) begin e.bf = 2'd2; e.tag = bad_tag(e.c2); end
            else if (ref_bad(e.cd, rd)) begin e.bf = 2'd3; e.tag = bad_tag(e.cd); end
            else if (e.c2 == 3'd4 || e.cd == 3'd4) e.tag = "R4";
            else e.tag = "R3";
            e.badreg = (e.bf != 2'd0);
            e.ok = !e.badreg;
            e.trap = e.badreg ? 3'd6 : 3'd0;
        end
        sb.push_back(e);
        @(posedge clk);
        #1;
        in_insn = w;
        in_vld = 1'b1;
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
        in_vld = 1'b0;
        in_insn = 32'hFFFF_FFFF;
    endtask

    // Monitor: pops and compares at the falling edge.
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (sb.size() == 0) begin
                check("R11 unexpected strobe", 32'(out_vld), 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({"R12 ok ", e.tag}, 32'(out_ok), 32'(e.ok));
                check({"R12 unimpl ", e.tag}, 32'(out_unimpl), 32'(e.unimpl));
                check({"R12 badreg ", e.tag}, 32'(out_badreg), 32'(e.badreg));
                check({"R8 trap ", e.tag}, 32'(out_trap), 32'(e.trap));
                check({"R10 field ", e.tag}, 32'(out_badfield), 32'(e.bf));
                check("R2 fields", {out_opc, out_rs1, out_rs2, out_rd},
                      {e.opc, e.r1, e.r2, e.rd});
                check({"R3 classes ", e.tag}, {out_cls_rs1, out_cls_rs2, out_cls_rd},
                      {e.c1, e.c2, e.cd});
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        check("R11 reset strobe", 32'(out_vld), 32'd0);
        check("R11 reset outputs", {out_ok, out_unimpl, out_badreg, out_trap, out_opc},
              32'd0);
        rst_n = 1'b1;
        idle();
        // R1/R3/R9: every code in both groups, registers all zero
        for (int g = 0; g < 2; g++)
            for (int op = 0; op < 512; op++)
                send(2'b10, g ? 6'b110101 : 6'b110100, 9'(op), 5'd0, 5'd0, 5'd0);
        // R1: words outside both groups, including group-like codes
        send(2'b11, 6'b110100, 9'h041, 5'd0, 5'd0, 5'd0);
        send(2'b00, 6'b110101, 9'h051, 5'd0, 5'd0, 5'd0);
        send(2'b10, 6'b110110, 9'h042, 5'd0, 5'd0, 5'd0);
        send(2'b10, 6'b100100, 9'h001, 5'd0, 5'd0, 5'd0);
        // R5/R6/R7/R10/R4: register parities for every supported code
        for (int g = 0; g < 2; g++)
            for (int op = 0; op < 512; op++)
                if (ref_tbl(g != 0, 9'(op)) != '0)
                    for (int a = 0; a < 5; a++)
                        for (int b = 0; b < 5; b++)
                            for (int c = 0; c < 5; c++)
                                send(2'b10, g ? 6'b110101 : 6'b110100, 9'(op),
                                     5'(a * 7 % 32), 5'(b * 5 + 16), 5'(c * 3));
        // R11: idle after a stream
        idle();
        @(negedge clk);
        @(negedge clk);
        check("R11 idle strobe", 32'(out_vld), 32'd0);
        check("R11 idle outputs", {out_opc, out_rs1, out_rs2, out_rd}, 32'd0);
        check("R11 scoreboard drained", 32'(sb.size()), 32'd0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule